// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Controller

This block turns a single pulse-width-modulated request into two gate commands for a half-bridge: one for the high-side switch and one for the low-side synchronous switch. The gaps between the two commands are not fixed delays. Each handoff waits for feedback showing that the switch being turned off has actually stopped conducting. The feedback comes from three analog comparators, each presented as a digital "below threshold" flag. One flag watches the switch node, one watches the high-side gate, and one watches the low-side gate.

When the PWM request falls, the high-side command is dropped. The low-side command is then granted only after both the switch-node flag and the high-side gate flag report low. A cycle timeout can override this wait, and a status output records that the override was used. When the PWM request rises, the low-side command is held for a programmable propagation delay and then dropped. The high-side command is then granted only when the low-side gate flag reports low. This direction has no timeout. A supply-good input from an undervoltage detector keeps both commands off while the supply is not valid.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While `supply_ok_i` is 0, both gate outputs are 0 from the first clock edge after it is sampled low. `forced_o` is cleared at the same time.
- R2: `hs_gate_o` and `ls_gate_o` are never 1 in the same cycle.
- R3: On the first edge at which `supply_ok_i` is sampled high, the controller enters an all-off wait. It then follows the handoff sequence for the current synchronized PWM level: low-side if PWM is 0, high-side if PWM is 1.
- R4: A falling `pwm_i` drops `hs_gate_o` on the third clock edge after the change (two synchronizer flops plus one state flop). `ls_gate_o` asserts only after both `sw_low_i` and `hs_gate_low_i` have been seen at 1 through their synchronizers.
- R5: If the two low flags are not both seen within `TMO_CYC` cycles of the high-side command dropping, `ls_gate_o` is forced to 1 exactly `TMO_CYC` edges after that drop.
- R6: A rising `pwm_i` keeps `ls_gate_o` at 1 for `PROP_CYC` edges after the controller sees the rise, and then drops it. `hs_gate_o` asserts only once `ls_gate_low_i` is seen at 1, with no timeout however long that takes.
- R7: `forced_o` becomes 1 on the edge where a timeout forces the low-side command. It holds through later high-side phases and returns to 0 on the next low-side turn-on granted by the flags.
- R8: A PWM reversal while a handoff is waiting abandons that handoff and starts the opposite sequence. No gate asserts for the abandoned direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | 1 when the supply is above the lockout threshold |
| pwm_i | input | 1 | Duty-ratio request; 1 requests the high side |
| sw_low_i | input | 1 | 1 when the switch node is below threshold |
| hs_gate_low_i | input | 1 | 1 when the high-side gate is below threshold |
| ls_gate_low_i | input | 1 | 1 when the low-side gate is below threshold |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| forced_o | output | 1 | 1 after a timeout forced the low-side turn-on |

## Verification
Two events can fall in the same cycle: the timeout expiring, and the arrival of the low flags or of a PWM reversal. These can collide in the falling-edge wait. The bench counts edges from the high-side drop and lands the flags on cycles just inside the timeout window. It checks that a flag-granted turn-on leaves `forced_o` at 0, and that a late turn-on happens exactly on the timeout edge with `forced_o` set. Reversals are placed in both wait states. The bench then confirms that the abandoned gate stays low while the opposite gate follows on its expected edge.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

   typedef enum logic [2:0] {
      ST_OFF     = 3'd0,
      ST_WAIT_LS = 3'd1,
      ST_LS_ON   = 3'd2,
      ST_LS_PROP = 3'd3,
      ST_WAIT_HS = 3'd4,
      ST_HS_ON   = 3'd5
   } hb_state_e;

   function automatic int hb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= '0;
         else        pipe[s] <= pipe[s-1];
      end
   end

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/hb_dwell_timer.sv
module hb_dwell_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_o <= '0;
      else if (clear_i)           cnt_o <= '0;
      else if (cnt_o != CNT_TOP)  cnt_o <= cnt_o + 1'b1;
   end

endmodule

// File: rtl/hb_handoff_fsm.sv
module hb_handoff_fsm
   import hb_dt_pkg::*;
#(
   parameter int TMO_CYC  = 8,
   parameter int PROP_CYC = 1,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok_i,
   input  logic             pwm_s_i,
   input  logic             sw_low_s_i,
   input  logic             hsg_low_s_i,
   input  logic             lsg_low_s_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             cnt_clear_o,
   output logic             hs_on_o,
   output logic             ls_on_o,
   output logic             forced_o
);

   localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_CYC - 1);
   localparam logic [CNT_W-1:0] PROP_LAST = CNT_W'(PROP_CYC - 1);

   hb_state_e state_q, state_d;
   logic      forced_d;
   logic      both_low;
   logic      tmo_hit;

   assign both_low = sw_low_s_i & hsg_low_s_i;
   assign tmo_hit  = (cnt_i == TMO_LAST);

   always_comb begin
      state_d  = state_q;
      forced_d = forced_o;
      if (!supply_ok_i) begin
         state_d  = ST_OFF;
         forced_d = 1'b0;
      end else begin
         unique case (state_q)
            ST_OFF:     state_d = pwm_s_i ? ST_WAIT_HS : ST_WAIT_LS;
            ST_HS_ON:   if (!pwm_s_i) state_d = ST_WAIT_LS;
            ST_WAIT_LS: begin
               if (pwm_s_i) begin
                  state_d = ST_WAIT_HS;
               end else if (both_low) begin
                  state_d  = ST_LS_ON;
                  forced_d = 1'b0;
               end else if (tmo_hit) begin
                  state_d  = ST_LS_ON;
                  forced_d = 1'b1;
               end
            end
            ST_LS_ON:   if (pwm_s_i) state_d = ST_LS_PROP;
            ST_LS_PROP: begin
               if (!pwm_s_i)                state_d = ST_LS_ON;
               else if (cnt_i == PROP_LAST) state_d = ST_WAIT_HS;
            end
            ST_WAIT_HS: begin
               if (!pwm_s_i)        state_d = ST_WAIT_LS;
               else if (lsg_low_s_i) state_d = ST_HS_ON;
            end
            default:    state_d = ST_OFF;
         endcase
      end
   end

   assign cnt_clear_o = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_OFF;
         forced_o <= 1'b0;
      end else begin
         state_q  <= state_d;
         forced_o <= forced_d;
      end
   end

   assign hs_on_o = (state_q == ST_HS_ON);
   assign ls_on_o = (state_q == ST_LS_ON) || (state_q == ST_LS_PROP);

   p_lockout_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok_i |=> (!hs_on_o && !ls_on_o && !forced_o))
      else $error("lockout did not clear the gates");

   p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_on_o && ls_on_o))
      else $error("both gates on");

   p_start_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(supply_ok_i) |=> (!hs_on_o && !ls_on_o))
      else $error("supply release did not start all-off");

   p_fall_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_on_o) |-> !ls_on_o)
      else $error("low side followed high side with no gap");

   p_ls_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_on_o) |-> (forced_o || $past(both_low)))
      else $error("low side granted without feedback or timeout");

   p_hs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_on_o) |-> $past(lsg_low_s_i))
      else $error("high side granted before low gate seen low");

   p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(forced_o) |-> $rose(ls_on_o))
      else $error("timeout flag set without a low-side turn-on");

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
   import hb_dt_pkg::*;
#(
   parameter int TMO_CYC     = 8,
   parameter int PROP_CYC    = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok_i,
   input  logic pwm_i,
   input  logic sw_low_i,
   input  logic hs_gate_low_i,
   input  logic ls_gate_low_i,
   output logic hs_gate_o,
   output logic ls_gate_o,
   output logic forced_o
);

   localparam int CNT_MAX = hb_max(TMO_CYC, PROP_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int N_SYNC  = 4;

   if (TMO_CYC < 1) begin : g_bad_tmo
      $error("TMO_CYC must be at least 1");
   end
   if (PROP_CYC < 1) begin : g_bad_prop
      $error("PROP_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [N_SYNC-1:0] raw_in, syn_in;
   logic [CNT_W-1:0]  cnt;
   logic              cnt_clear;

   assign raw_in = {ls_gate_low_i, hs_gate_low_i, sw_low_i, pwm_i};

   hb_sync #(
      .WIDTH  (N_SYNC),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   hb_dwell_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (cnt_clear),
      .cnt_o   (cnt)
   );

   hb_handoff_fsm #(
      .TMO_CYC  (TMO_CYC),
      .PROP_CYC (PROP_CYC),
      .CNT_W    (CNT_W)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok_i (supply_ok_i),
      .pwm_s_i     (syn_in[0]),
      .sw_low_s_i  (syn_in[1]),
      .hsg_low_s_i (syn_in[2]),
      .lsg_low_s_i (syn_in[3]),
      .cnt_i       (cnt),
      .cnt_clear_o (cnt_clear),
      .hs_on_o     (hs_gate_o),
      .ls_on_o     (ls_gate_o),
      .forced_o    (forced_o)
   );

endmodule

// File: tb/test_hb_deadtime_ctrl.sv
module test_hb_deadtime_ctrl;

   localparam int TMO  = 20;
   localparam int PROP = 3;

   logic clk = 1'b0;
   logic rst_n, supply_ok, pwm, sw_low, hsg_low, lsg_low;
   logic hs, ls, forced;
   int   total = 0;
   int   bad = 0;
   int   overlap_cnt = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   hb_deadtime_ctrl #(
      .TMO_CYC     (TMO),
      .PROP_CYC    (PROP),
      .SYNC_STAGES (2)
   ) i_hb_deadtime_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .supply_ok_i   (supply_ok),
      .pwm_i         (pwm),
      .sw_low_i      (sw_low),
      .hs_gate_low_i (hsg_low),
      .ls_gate_low_i (lsg_low),
      .hs_gate_o     (hs),
      .ls_gate_o     (ls),
      .forced_o      (forced)
   );

   always @(negedge clk) if (rst_n && hs && ls) overlap_cnt++;

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic act, input logic exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", what, act, exp);
      end
   endtask

   task automatic t_reset();
      chk(hs, 1'b0, "reset hs");
      chk(ls, 1'b0, "reset ls");
      chk(forced, 1'b0, "reset forced");
   endtask

   task automatic t_lockout();
      for (int i = 0; i < 6; i++) begin
         pwm = ~pwm;
         edges(4);
         chk(hs, 1'b0, "R1 lockout hs");
         chk(ls, 1'b0, "R1 lockout ls");
      end
      pwm = 1'b0;
      edges(4);
   endtask

   task automatic t_startup();
      supply_ok = 1'b1;
      edges(1);
      chk(hs, 1'b0, "R3 all-off wait hs");
      chk(ls, 1'b0, "R3 all-off wait ls");
      edges(1);
      chk(ls, 1'b1, "R3 low-side sequence for pwm=0");
   endtask

   task automatic t_rise_normal();
      lsg_low = 1'b0;
      pwm = 1'b1;
      edges(2);
      chk(ls, 1'b1, "R6 ls before sync");
      edges(1);
      chk(ls, 1'b1, "R6 ls held at entry");
      edges(PROP - 1);
      chk(ls, 1'b1, "R6 ls held last prop cycle");
      edges(1);
      chk(ls, 1'b0, "R6 ls dropped after prop");
      chk(hs, 1'b0, "R6 hs waits");
      edges(30);
      chk(hs, 1'b0, "R6 no timeout on rising handoff");
      lsg_low = 1'b1;
      edges(2);
      chk(hs, 1'b0, "R6 hs before flag synced");
      edges(1);
      chk(hs, 1'b1, "R6 hs granted");
      chk(ls, 1'b0, "R6 ls stays off");
   endtask

   task automatic t_fall_normal();
      sw_low = 1'b0;
      hsg_low = 1'b0;
      pwm = 1'b0;
      edges(2);
      chk(hs, 1'b1, "R4 hs before sync");
      edges(1);
      chk(hs, 1'b0, "R4 hs dropped on third edge");
      chk(ls, 1'b0, "R4 ls waits");
      hsg_low = 1'b1;
      edges(3);
      chk(ls, 1'b0, "R4 one flag is not enough");
      sw_low = 1'b1;
      edges(2);
      chk(ls, 1'b0, "R4 ls before both flags synced");
      edges(1);
      chk(ls, 1'b1, "R4 ls granted by flags");
      chk(forced, 1'b0, "R7 normal grant leaves flag clear");
   endtask

   task automatic go_high();
      pwm = 1'b1;
      edges(3 + PROP + 1);
      chk(hs, 1'b1, "R6 hs reached");
   endtask

   task automatic t_timeout();
      go_high();
      sw_low = 1'b0;
      hsg_low = 1'b0;
      pwm = 1'b0;
      edges(3);
      chk(hs, 1'b0, "R5 hs dropped");
      edges(TMO - 1);
      chk(ls, 1'b0, "R5 ls one edge before timeout");
      chk(forced, 1'b0, "R7 flag before timeout");
      edges(1);
      chk(ls, 1'b1, "R5 ls forced at timeout");
      chk(forced, 1'b1, "R7 flag set by timeout");
   endtask

   task automatic t_flag_hold();
      go_high();
      chk(forced, 1'b1, "R7 flag holds through high side");
      sw_low = 1'b1;
      hsg_low = 1'b1;
      pwm = 1'b0;
      edges(3);
      chk(ls, 1'b0, "R4 gap after hs drop");
      edges(1);
      chk(ls, 1'b1, "R7 normal grant");
      chk(forced, 1'b0, "R7 flag cleared by normal grant");
   endtask

   task automatic t_abort_fall();
      go_high();
      sw_low = 1'b0;
      hsg_low = 1'b0;
      pwm = 1'b0;
      edges(3);
      chk(hs, 1'b0, "R8 hs dropped");
      edges(2);
      pwm = 1'b1;
      edges(3);
      chk(ls, 1'b0, "R8 abandoned low side never asserted");
      chk(hs, 1'b0, "R8 hs still off in wait");
      edges(1);
      chk(hs, 1'b1, "R8 high side resumes");
   endtask

   task automatic t_abort_rise();
      sw_low = 1'b1;
      hsg_low = 1'b1;
      pwm = 1'b0;
      edges(4);
      chk(ls, 1'b1, "R8 setup ls on");
      lsg_low = 1'b0;
      pwm = 1'b1;
      edges(3 + PROP);
      chk(ls, 1'b0, "R8 ls dropped, waiting for hs");
      pwm = 1'b0;
      edges(3);
      chk(hs, 1'b0, "R8 abandoned high side never asserted");
      chk(ls, 1'b0, "R8 ls off in falling wait");
      edges(1);
      chk(ls, 1'b1, "R8 low side resumes");
      lsg_low = 1'b1;
   endtask

   task automatic t_lockout_mid();
      go_high();
      supply_ok = 1'b0;
      edges(1);
      chk(hs, 1'b0, "R1 lockout mid-run hs");
      chk(ls, 1'b0, "R1 lockout mid-run ls");
      chk(forced, 1'b0, "R1 lockout clears flag");
   endtask

   initial begin
      rst_n = 1'b0; supply_ok = 1'b0; pwm = 1'b0;
      sw_low = 1'b1; hsg_low = 1'b1; lsg_low = 1'b1;
      edges(3);
      t_reset();
      rst_n = 1'b1;
      edges(1);
      t_lockout();
      t_startup();
      t_rise_normal();
      t_fall_normal();
      t_timeout();
      t_flag_hold();
      t_abort_fall();
      t_abort_rise();
      t_lockout_mid();
      edges(4);
      total++;
      if (overlap_cnt != 0) begin
         bad++;
         $display("FAIL R2 overlap cycles: actual=%0d expected=0", overlap_cnt);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule